// File: doc/BRIEF.md
# USB Device State and Wakeup Controller

This block follows the device side of USB enumeration and power handling. It starts in the powered state and moves to the default state on an end-of-bus-reset strobe. Software then commits a function address and marks the device configured through a small register-write port. The block also flags suspend (bus idle) and resume, and handles a device-initiated remote wakeup.

The address path is guarded. A freshly written function address is only held pending. It becomes the effective address once the endpoint-0 transmit-complete indication for the status stage has gone high and then low again. Resume detection must work with the clock stopped. For that reason, a bus resume or an enabled external-resume pin event is caught by an asynchronously set flop, synchronised, and turned into a wakeup status flag.

Remote wakeup happens in two steps. The external pin only raises the wakeup flag. The K-state request to the line driver starts later, when software writes a separate ready bit. It lasts a parameterised number of cycles, and then the ready bit clears itself.

Top module: `usb_devstate_ctrl`

## Requirements
- R1: After reset, `dev_state` is 0 (powered), `dev_addr` is 0, `int_status` is 0, and `irq` and `kstate_req` are low.
- R2: A one-cycle `ev_bus_reset` strobe makes `dev_state` 1 (default) and `dev_addr` 0 on the next cycle, and sets `int_status` bit 0.
- R3: A write with `wr_sel`=1 whose bit 7 (function enable) is 1, made while global bit 0 (address enable) is set, stores bits 6:0 as a pending address. `dev_addr` keeps its old value until `ep0_txcomp` has been seen high and then low. On the cycle after it is seen low, `dev_addr` takes the pending value and `dev_state` becomes 2 (address).
- R4: A function-address write made while global bit 0 is clear is ignored: `dev_addr` and `dev_state` do not change, even after a later `ep0_txcomp` pulse.
- R5: Global register writes use `wr_sel`=0 and replace bits 3:0. In the address state, a set bit 1 (configured) moves `dev_state` to 3 one cycle after the write. In state 3, a cleared bit 1 returns `dev_state` to 2.
- R6: `ev_suspend` sets `int_status` bit 1. `irq` is high only when some status bit is set and its mask bit is also set. The mask is written with `wr_sel`=2, data bits 2:0.
- R7: A write with `wr_sel`=2'd3 clears each status bit whose data bit is 1. Zero bits leave status unchanged. A set event in the same cycle wins over a clear.
- R8: A rising level on `bus_resume_async` is captured without a clock edge. `int_status` bit 2 (wakeup) is set on the third rising clock edge after it.
- R9: A rising `ext_resume_pin` sets `int_status` bit 2 only when global bit 2 (external resume enable) is set. Otherwise it has no effect.
- R10: An external resume event never raises `kstate_req`. Writing global bit 3 (remote-wakeup ready) as 1 raises `kstate_req` from the next cycle for exactly K_CYCLES cycles. After that the ready bit clears itself.
- R11: A bus reset from any state clears global bits 3:0 and any pending address. A function-address write afterwards is therefore ignored until address enable is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_bus_reset | input | 1 | End-of-bus-reset strobe |
| ev_suspend | input | 1 | Bus-idle (suspend) detected strobe |
| bus_resume_async | input | 1 | Asynchronous resume seen on the bus |
| ext_resume_pin | input | 1 | Asynchronous external resume request |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 global, 1 address, 2 mask, 3 clear |
| wr_data | input | ADDR_W+1 | Write data |
| ep0_txcomp | input | 1 | Endpoint-0 transmit-complete flag level |
| dev_state | output | 2 | 0 powered, 1 default, 2 address, 3 configured |
| dev_addr | output | ADDR_W | Effective device address |
| int_status | output | 3 | Bit 0 bus reset, bit 1 suspend, bit 2 wakeup |
| irq | output | 1 | Combined masked interrupt |
| kstate_req | output | 1 | Request to drive K-state on the bus |

## Verification
Several properties are checked on every cycle. A bus reset always lands in the default state with address zero. The effective address only moves after a bus reset or after a low transmit-complete level. The configured state is only entered from the address state. Suspend strobes always set their flag. A wakeup flag only rises after a synchronised edge. The K-state request only starts from a software ready write. Other behaviour needs the bench's scenarios: the full raise-then-clear handshake that commits an address, ignored writes before address enable, the gating of the external pin, the exact length of the K-state burst, and the mask/clear interplay on `irq`.

// File: rtl/usbds_pkg.sv
package usbds_pkg;
  typedef enum logic [1:0] {
    ST_POWERED    = 2'd0,
    ST_DEFAULT    = 2'd1,
    ST_ADDRESS    = 2'd2,
    ST_CONFIGURED = 2'd3
  } dev_state_e;

  typedef enum logic [1:0] {
    SEL_GLOBAL = 2'd0,
    SEL_FADDR  = 2'd1,
    SEL_MASK   = 2'd2,
    SEL_CLEAR  = 2'd3
  } reg_sel_e;

  localparam int NUM_IRQ    = 3;
  localparam int IRQ_BUSRST = 0;
  localparam int IRQ_SUSP   = 1;
  localparam int IRQ_WAKE   = 2;

  localparam int G_ADDR_EN = 0;
  localparam int G_CONFIG  = 1;
  localparam int G_EXT_EN  = 2;
  localparam int G_RWAKE   = 3;

  // status update: set events win over clear requests
  function automatic logic [NUM_IRQ-1:0] status_next(
    input logic [NUM_IRQ-1:0] cur,
    input logic [NUM_IRQ-1:0] set_v,
    input logic [NUM_IRQ-1:0] clr_v
  );
    return (cur & ~clr_v) | set_v;
  endfunction
endpackage

// File: rtl/usbds_wake_sync.sv
module usbds_wake_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_async,
  output logic wake_rise
);
  logic cap_q, s1_q, s2_q, s2_d_q;

  // capture flop: set without a clock, released once seen and source gone
  always_ff @(posedge clk or posedge wake_async or negedge rst_n) begin
    if (!rst_n)          cap_q <= 1'b0;
    else if (wake_async) cap_q <= 1'b1;
    else if (s2_q)       cap_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      s2_d_q <= 1'b0;
    end else begin
      s1_q   <= cap_q;
      s2_q   <= s1_q;
      s2_d_q <= s2_q;
    end
  end

  assign wake_rise = s2_q & ~s2_d_q;
endmodule

// File: rtl/usbds_kstate_timer.sv
module usbds_kstate_timer #(
  parameter int K_CYCLES = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic active
);
  localparam int CW = (K_CYCLES > 2) ? $clog2(K_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(K_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          ready_q;
  logic          done;

  assign done = ready_q && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      cnt_q   <= '0;
    end else if (abort) begin
      ready_q <= 1'b0;
      cnt_q   <= '0;
    end else if (ready_q) begin
      if (done) begin
        ready_q <= 1'b0;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (start) begin
      ready_q <= 1'b1;
    end
  end

  assign active = ready_q;
endmodule

// File: rtl/usbds_int_ctrl.sv
module usbds_int_ctrl import usbds_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] set_vec,
  input  logic               mask_wr,
  input  logic               clr_wr,
  input  logic [NUM_IRQ-1:0] wr_bits,
  output logic [NUM_IRQ-1:0] status,
  output logic [NUM_IRQ-1:0] mask,
  output logic               irq
);
  logic [NUM_IRQ-1:0] clr_vec;
  assign clr_vec = clr_wr ? wr_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '0;
    end else begin
      status <= status_next(status, set_vec, clr_vec);
      if (mask_wr) mask <= wr_bits;
    end
  end

  assign irq = |(status & mask);
endmodule

// File: rtl/usb_devstate_ctrl.sv
module usb_devstate_ctrl import usbds_pkg::*; #(
  parameter int ADDR_W   = 7,
  parameter int K_CYCLES = 100000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_bus_reset,
  input  logic               ev_suspend,
  input  logic               bus_resume_async,
  input  logic               ext_resume_pin,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [ADDR_W:0]    wr_data,
  input  logic               ep0_txcomp,
  output logic [1:0]         dev_state,
  output logic [ADDR_W-1:0]  dev_addr,
  output logic [NUM_IRQ-1:0] int_status,
  output logic               irq,
  output logic               kstate_req
);
  localparam int FEN_BIT = ADDR_W;

  // decoded write strobes
  logic gwr, fwr, mwr, cwr, rwake_wr;
  assign gwr      = wr_en && (wr_sel == SEL_GLOBAL);
  assign fwr      = wr_en && (wr_sel == SEL_FADDR);
  assign mwr      = wr_en && (wr_sel == SEL_MASK);
  assign cwr      = wr_en && (wr_sel == SEL_CLEAR);
  assign rwake_wr = gwr && wr_data[G_RWAKE];

  logic [2:0]        glob_q;
  logic              pend_q, seen_q;
  logic [ADDR_W-1:0] pend_addr_q, addr_q;
  dev_state_e        st_q, st_d;

  logic faddr_accept, addr_apply, wake_async, wake_rise;
  logic [NUM_IRQ-1:0] int_mask;

  assign faddr_accept = fwr && wr_data[FEN_BIT] && glob_q[G_ADDR_EN] && !ev_bus_reset;
  assign addr_apply   = pend_q && seen_q && !ep0_txcomp && !faddr_accept && !ev_bus_reset;
  assign wake_async   = bus_resume_async | (ext_resume_pin & glob_q[G_EXT_EN]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            glob_q <= '0;
    else if (ev_bus_reset) glob_q <= '0;
    else if (gwr)          glob_q <= wr_data[2:0];
  end

  // pending address: committed after txcomp seen high then low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0; seen_q <= 1'b0; pend_addr_q <= '0; addr_q <= '0;
    end else if (ev_bus_reset) begin
      pend_q <= 1'b0; seen_q <= 1'b0; addr_q <= '0;
    end else if (faddr_accept) begin
      pend_q <= 1'b1; seen_q <= 1'b0; pend_addr_q <= wr_data[ADDR_W-1:0];
    end else if (addr_apply) begin
      pend_q <= 1'b0; seen_q <= 1'b0; addr_q <= pend_addr_q;
    end else if (pend_q && ep0_txcomp) begin
      seen_q <= 1'b1;
    end
  end

  always_comb begin
    st_d = st_q;
    if (ev_bus_reset)    st_d = ST_DEFAULT;
    else if (addr_apply) st_d = ST_ADDRESS;
    else if (st_q == ST_ADDRESS && glob_q[G_CONFIG])     st_d = ST_CONFIGURED;
    else if (st_q == ST_CONFIGURED && !glob_q[G_CONFIG]) st_d = ST_ADDRESS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_POWERED;
    else        st_q <= st_d;
  end

  usbds_wake_sync u_wake (
    .clk(clk), .rst_n(rst_n), .wake_async(wake_async), .wake_rise(wake_rise)
  );

  usbds_kstate_timer #(.K_CYCLES(K_CYCLES)) u_ktimer (
    .clk(clk), .rst_n(rst_n), .start(rwake_wr), .abort(ev_bus_reset), .active(kstate_req)
  );

  usbds_int_ctrl u_int (
    .clk(clk), .rst_n(rst_n),
    .set_vec({wake_rise, ev_suspend, ev_bus_reset}),
    .mask_wr(mwr), .clr_wr(cwr), .wr_bits(wr_data[NUM_IRQ-1:0]),
    .status(int_status), .mask(int_mask), .irq(irq)
  );

  assign dev_state = st_q;
  assign dev_addr  = addr_q;
endmodule

// File: rtl/usbds_checker.sv
module usbds_checker import usbds_pkg::*; #(
  parameter int ADDR_W = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ev_bus_reset,
  input logic               ev_suspend,
  input logic               ep0_txcomp,
  input logic [1:0]         dev_state,
  input logic [ADDR_W-1:0]  dev_addr,
  input logic [NUM_IRQ-1:0] int_status,
  input logic               kstate_req,
  input logic               wake_rise,
  input logic               rwake_wr
);
  assert_busrst_default_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_reset |=> (dev_state == ST_DEFAULT && dev_addr == '0 && int_status[IRQ_BUSRST]));

  assert_addr_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dev_addr) |-> ($past(ev_bus_reset) || !$past(ep0_txcomp)));

  assert_cfg_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_state == ST_CONFIGURED && $past(dev_state) != ST_CONFIGURED)
      |-> $past(dev_state) == ST_ADDRESS);

  assert_susp_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_suspend |=> int_status[IRQ_SUSP]);

  assert_wake_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_status[IRQ_WAKE]) |-> $past(wake_rise));

  assert_kreq_by_sw_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kstate_req) |-> $past(rwake_wr));
endmodule

bind usb_devstate_ctrl usbds_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_bus_reset(ev_bus_reset), .ev_suspend(ev_suspend),
  .ep0_txcomp(ep0_txcomp), .dev_state(dev_state), .dev_addr(dev_addr),
  .int_status(int_status), .kstate_req(kstate_req), .wake_rise(wake_rise),
  .rwake_wr(rwake_wr)
);

// File: tb/tb_usb_devstate_ctrl.sv
module tb_usb_devstate_ctrl;
  localparam int KC = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_bus_reset = 0, ev_suspend = 0, bus_resume_async = 0, ext_resume_pin = 0;
  logic wr_en = 0, ep0_txcomp = 0;
  logic [1:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] dev_state;
  logic [6:0] dev_addr;
  logic [2:0] int_status;
  logic irq, kstate_req;

  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  usb_devstate_ctrl #(.ADDR_W(7), .K_CYCLES(KC)) dut (
    .clk(clk), .rst_n(rst_n), .ev_bus_reset(ev_bus_reset), .ev_suspend(ev_suspend),
    .bus_resume_async(bus_resume_async), .ext_resume_pin(ext_resume_pin),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .ep0_txcomp(ep0_txcomp),
    .dev_state(dev_state), .dev_addr(dev_addr), .int_status(int_status),
    .irq(irq), .kstate_req(kstate_req)
  );

  // behavioural reference model
  int m_st = 0, m_addr = 0, m_paddr = 0, m_wcnt = 0, m_kcnt = 0;
  bit m_pend = 0, m_seen = 0, m_aen = 0, m_cfg = 0, m_ext = 0, m_kready = 0;
  bit [2:0] m_status = 0, m_mask = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_addr = 0; m_paddr = 0; m_wcnt = 0; m_kcnt = 0;
      m_pend = 0; m_seen = 0; m_aen = 0; m_cfg = 0; m_ext = 0; m_kready = 0;
      m_status = 0; m_mask = 0;
    end else begin
      bit br, acc, app, wset;
      bit [2:0] clr;
      br   = ev_bus_reset;
      acc  = wr_en && wr_sel == 1 && wr_data[7] && m_aen && !br;
      app  = m_pend && m_seen && !ep0_txcomp && !acc && !br;
      wset = 0;
      if (m_wcnt > 0) begin m_wcnt--; if (m_wcnt == 0) wset = 1; end
      clr = (wr_en && wr_sel == 3) ? wr_data[2:0] : 3'b0;
      m_status = (m_status & ~clr) | {wset, ev_suspend, br};
      if (wr_en && wr_sel == 2) m_mask = wr_data[2:0];
      if (br) begin m_kready = 0; m_kcnt = 0; end
      else if (m_kready) begin
        if (m_kcnt == KC - 1) begin m_kready = 0; m_kcnt = 0; end else m_kcnt++;
      end else if (wr_en && wr_sel == 0 && wr_data[3]) m_kready = 1;
      if (br) m_st = 1;
      else if (app) m_st = 2;
      else if (m_st == 2 && m_cfg) m_st = 3;
      else if (m_st == 3 && !m_cfg) m_st = 2;
      if (br) begin m_pend = 0; m_seen = 0; m_addr = 0; end
      else if (acc) begin m_pend = 1; m_seen = 0; m_paddr = int'(wr_data[6:0]); end
      else if (app) begin m_pend = 0; m_seen = 0; m_addr = m_paddr; end
      else if (m_pend && ep0_txcomp) m_seen = 1;
      if (br) begin m_aen = 0; m_cfg = 0; m_ext = 0; end
      else if (wr_en && wr_sel == 0) begin
        m_aen = wr_data[0]; m_cfg = wr_data[1]; m_ext = wr_data[2];
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the clock edge
  always @(posedge clk) begin
    #5;
    chk("R3/R5 model state", int'(dev_state), m_st);
    chk("R3 model addr", int'(dev_addr), m_addr);
    chk("R7 model status", int'(int_status), int'(m_status));
    chk("R6 model irq", int'(irq), int'(|(m_status & m_mask)));
    chk("R10 model kreq", int'(kstate_req), int'(m_kready));
  end

  task automatic wr(input int sel, input int data);
    @(negedge clk); wr_en = 1; wr_sel = 2'(sel); wr_data = 8'(data);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic strobe(input bit susp);
    @(negedge clk); if (susp) ev_suspend = 1; else ev_bus_reset = 1;
    @(negedge clk); ev_suspend = 0; ev_bus_reset = 0;
  endtask

  task automatic wake(input bit ext);
    @(negedge clk);
    if (ext) ext_resume_pin = 1; else bus_resume_async = 1;
    if (!ext || m_ext) m_wcnt = 3;
    @(negedge clk); ext_resume_pin = 0; bus_resume_async = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tx_pulse();
    @(negedge clk); ep0_txcomp = 1;
    @(negedge clk); ep0_txcomp = 0;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    chk("R1 reset state", int'(dev_state), 0);
    chk("R1 reset addr", int'(dev_addr), 0);
    chk("R1 reset status", int'({int_status, irq, kstate_req}), 0);
    @(negedge clk); rst_n = 1;
    idle(2);

    // suspend, mask, clear
    strobe(1);
    chk("R6 suspend flag", int'(int_status[1]), 1);
    chk("R6 unmasked irq low", int'(irq), 0);
    wr(2, 3'b010);
    chk("R6 masked irq high", int'(irq), 1);
    wr(3, 3'b000);
    chk("R7 zero clear no effect", int'(int_status[1]), 1);
    wr(3, 3'b010);
    chk("R7 clear suspend", int'(int_status[1]), 0);
    chk("R7 irq drops", int'(irq), 0);

    // bus reset
    strobe(0);
    chk("R2 default state", int'(dev_state), 1);
    chk("R2 reset flag", int'(int_status[0]), 1);
    wr(3, 3'b001);

    // address write before enable: ignored
    wr(1, 8'h80 | 8'h11);
    tx_pulse(); idle(1);
    chk("R4 addr unchanged", int'(dev_addr), 0);
    chk("R4 state unchanged", int'(dev_state), 1);

    // address commit handshake
    wr(0, 8'h01);
    wr(1, 8'h80 | 8'h25);
    idle(2);
    chk("R3 addr held before txcomp", int'(dev_addr), 0);
    @(negedge clk); ep0_txcomp = 1;
    @(negedge clk);
    @(negedge clk);
    chk("R3 addr held while txcomp high", int'(dev_addr), 0);
    ep0_txcomp = 0;
    @(negedge clk);
    chk("R3 addr committed", int'(dev_addr), 'h25);
    chk("R3 address state", int'(dev_state), 2);

    // configure
    wr(0, 8'h03); @(negedge clk);
    chk("R5 configured", int'(dev_state), 3);
    wr(0, 8'h01); @(negedge clk);
    chk("R5 back to address", int'(dev_state), 2);
    wr(0, 8'h03); @(negedge clk);
    chk("R5 configured again", int'(dev_state), 3);

    // bus resume
    wr(2, 3'b111);
    wake(0);
    chk("R8 not yet set", int'(int_status[2]), 0);
    idle(2);
    chk("R8 wakeup flag", int'(int_status[2]), 1);
    chk("R8 irq", int'(irq), 1);
    idle(3);
    wr(3, 3'b100);
    chk("R7 wakeup cleared", int'(int_status[2]), 0);

    // external pin gated off
    wake(1); idle(6);
    chk("R9 pin ignored when disabled", int'(int_status[2]), 0);

    // external pin enabled
    wr(0, 8'h07);
    wake(1); idle(4);
    chk("R9 pin sets wakeup", int'(int_status[2]), 1);
    chk("R10 no K on pin event", int'(kstate_req), 0);
    wr(3, 3'b100);

    // remote wakeup ready -> K burst
    wr(0, 8'h0F);
    begin
      int hi = 0;
      for (int i = 0; i < 40; i++) begin
        if (kstate_req) hi++;
        @(negedge clk);
      end
      chk("R10 K length", hi, KC);
    end
    chk("R10 K ended", int'(kstate_req), 0);

    // bus reset from configured
    strobe(0);
    chk("R11 default after reset", int'(dev_state), 1);
    chk("R11 addr zero", int'(dev_addr), 0);
    wr(1, 8'h80 | 8'h33);
    tx_pulse(); idle(1);
    chk("R11 enable cleared", int'(dev_addr), 0);
    chk("R11 state stays default", int'(dev_state), 1);

    idle(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule